// File: doc/BRIEF.md
# Write-Back Cache Control Sequencer

This block is the control state machine of a set-associative write-back data cache. It watches CPU load and store requests together with the hit result and the dirty state of the chosen victim line. On a miss it runs the bus side of the refill: a victim writeback first when the victim is dirty, then the line fetch. It also drives the enable of the tag and data arrays and the stall returned to the pipeline. The tag compare, the arrays, replacement and the bus datapath sit outside the block and only exchange strobes with it.

Two commands come from the pipeline. An invalidate clears every valid bit in one cycle. A flush walks every line of the cache with an internal set/way counter, and the counter value goes out to the datapath as the line address. The walk writes back each dirty line it finds and skips clean lines without using the bus. The dirty bit of a flushed line is cleared when its writeback starts, while the counter still points at that line. The counter moves on only after the bus acknowledge arrives, so the clear always lands on the line being written.

Top module: `wbc_ctrl`

## Requirements
- R1: In the ready state an asserted `inval_cmd` drives `clr_valid` high and `array_en` high in the same cycle, with `stall` low. It takes priority over `flush_cmd` and over any CPU request.
- R2: `array_en` is low only when the block is in the ready state, `req_rd` or `req_wr` is high, `hit` is high, `pipe_stall` is high and no command is pending. In every other case it is high.
- R3: A miss whose victim is dirty raises `stall` in the cycle of the request. From the next cycle, `bus_wr_req` is held until the cycle in which `bus_ack` is high, and `stall` stays high throughout.
- R4: A line fetch follows the cycle after a victim writeback ends, or the cycle after a miss whose victim is clean. During the fetch, `bus_rd_req` and `stall` stay high up to and including the cycle in which `bus_ack` is high.
- R5: If `pipe_stall` is high in the fetch's acknowledge cycle, the block enters a hold state. In that state `stall` is low, CPU requests start nothing, and the block returns to ready in the cycle after `pipe_stall` is seen low. Without `pipe_stall` it returns to ready directly.
- R6: A flush is accepted in the ready state when no invalidate is present, and `stall` is high from the accept cycle until the done cycle. Lines are visited in the order index = set*WAYS + way, from index 0 up: `flush_way` steps first and `flush_set` steps when `flush_way` wraps.
- R7: A clean line (`line_dirty` low while it is addressed) takes exactly one cycle and raises no bus request.
- R8: For a dirty line, `clr_dirty` pulses for one cycle while `flush_set`/`flush_way` address that line. `bus_wr_req` follows from the next cycle until `bus_ack`, and the address moves to the next line in the cycle after the acknowledge.
- R9: After the last line of the last set, `flush_done` pulses high for one cycle with `stall` high and the counter back at set 0, way 0. The block is ready in the following cycle.
- R10: `bus_rd_req` and `bus_wr_req` are never high together, and `stall` is high whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | CPU load request |
| req_wr | input | 1 | CPU store request |
| hit | input | 1 | Tag compare hit for the current request |
| line_dirty | input | 1 | Dirty bit of the victim line, or during flush of the line at flush_set/flush_way |
| pipe_stall | input | 1 | Pipeline is stalled by another unit |
| flush_cmd | input | 1 | Request to write back all dirty lines |
| inval_cmd | input | 1 | Request to clear all valid bits |
| bus_ack | input | 1 | Bus has completed the current line transfer |
| stall | output | 1 | Stall to the pipeline |
| array_en | output | 1 | Enable of the tag and data arrays |
| bus_rd_req | output | 1 | Line fetch request |
| bus_wr_req | output | 1 | Line writeback request |
| clr_dirty | output | 1 | Clear the dirty bit of the addressed line |
| clr_valid | output | 1 | Clear all valid bits |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| flush_set | output | SETW | Set index of the flush walk |
| flush_way | output | WAYW | Way index of the flush walk |

## Verification
All outputs are combinational in the registered state and the current inputs. A request or command therefore shows its strobes in the cycle it is driven, and the state it selects shows from the next clock edge. The bench drives every input on the falling edge and samples one time unit later, before the next rising edge. Its reference walks the same cycle list as the requirements: one cycle to accept, one per clean line, one plus the acknowledge latency per dirty line, then a done cycle. It compares the full output vector in each of those cycles. Combinational behaviour in the ready state is swept over all 64 input combinations with a reset between them, and flushes run over every dirty pattern of a 4-set, 2-way configuration.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        ST_READY    = 3'd0,
        ST_WR_LINE  = 3'd1,
        ST_RD_LINE  = 3'd2,
        ST_RD_HOLD  = 3'd3,
        ST_FL_CHECK = 3'd4,
        ST_FL_WRITE = 3'd5,
        ST_FL_DONE  = 3'd6
    } wbc_state_e;

    typedef struct packed {
        logic stall;
        logic array_en;
        logic bus_rd;
        logic bus_wr;
        logic clr_dirty;
        logic clr_valid;
        logic flush_done;
        logic walk_clear;
        logic walk_adv;
    } wbc_ctl_t;

endpackage

// File: rtl/wbc_flush_walk.sv
module wbc_flush_walk #(
    parameter  int SETS = 64,
    parameter  int WAYS = 4,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            adv,
    output logic [SETW-1:0] set_idx,
    output logic [WAYW-1:0] way_idx,
    output logic            last
);

    localparam logic [SETW-1:0] SET_MAX = SETW'(SETS - 1);
    localparam logic [WAYW-1:0] WAY_MAX = WAYW'(WAYS - 1);

    typedef struct packed {
        logic [SETW-1:0] set_idx;
        logic [WAYW-1:0] way_idx;
    } walk_t;

    walk_t walk_d, walk_q;

    // way is the inner index; set steps when way wraps
    always_comb begin
        walk_d = walk_q;
        if (clear) begin
            walk_d = '0;
        end else if (adv) begin
            if (walk_q.way_idx == WAY_MAX) begin
                walk_d.way_idx = '0;
                walk_d.set_idx = (walk_q.set_idx == SET_MAX) ? '0 : walk_q.set_idx + 1'b1;
            end else begin
                walk_d.way_idx = walk_q.way_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign set_idx = walk_q.set_idx;
    assign way_idx = walk_q.way_idx;
    assign last    = (walk_q.set_idx == SET_MAX) && (walk_q.way_idx == WAY_MAX);

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_rd,
    input  logic     req_wr,
    input  logic     hit,
    input  logic     line_dirty,
    input  logic     pipe_stall,
    input  logic     flush_cmd,
    input  logic     inval_cmd,
    input  logic     bus_ack,
    input  logic     walk_last,
    output wbc_ctl_t ctl
);

    typedef struct packed {
        wbc_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic access;

    assign access = req_rd | req_wr;

    always_comb begin
        fsm_d        = fsm_q;
        ctl          = '0;
        ctl.array_en = 1'b1;
        unique case (fsm_q.st)
            ST_READY: begin
                if (inval_cmd) begin
                    ctl.clr_valid = 1'b1;
                end else if (flush_cmd) begin
                    ctl.stall      = 1'b1;
                    ctl.walk_clear = 1'b1;
                    fsm_d.st       = ST_FL_CHECK;
                end else if (access && !hit) begin
                    ctl.stall = 1'b1;
                    fsm_d.st  = line_dirty ? ST_WR_LINE : ST_RD_LINE;
                end else if (access && pipe_stall) begin
                    // stalled hit: hold the array outputs
                    ctl.array_en = 1'b0;
                end
            end
            ST_WR_LINE: begin
                ctl.stall  = 1'b1;
                ctl.bus_wr = 1'b1;
                if (bus_ack) fsm_d.st = ST_RD_LINE;
            end
            ST_RD_LINE: begin
                ctl.stall  = 1'b1;
                ctl.bus_rd = 1'b1;
                if (bus_ack) fsm_d.st = pipe_stall ? ST_RD_HOLD : ST_READY;
            end
            ST_RD_HOLD: begin
                if (!pipe_stall) fsm_d.st = ST_READY;
            end
            ST_FL_CHECK: begin
                ctl.stall = 1'b1;
                if (line_dirty) begin
                    // clear while the counter still points at this line
                    ctl.clr_dirty = 1'b1;
                    fsm_d.st      = ST_FL_WRITE;
                end else begin
                    ctl.walk_adv = 1'b1;
                    fsm_d.st     = walk_last ? ST_FL_DONE : ST_FL_CHECK;
                end
            end
            ST_FL_WRITE: begin
                ctl.stall  = 1'b1;
                ctl.bus_wr = 1'b1;
                if (bus_ack) begin
                    ctl.walk_adv = 1'b1;
                    fsm_d.st     = walk_last ? ST_FL_DONE : ST_FL_CHECK;
                end
            end
            ST_FL_DONE: begin
                ctl.stall      = 1'b1;
                ctl.flush_done = 1'b1;
                fsm_d.st       = ST_READY;
            end
            default: fsm_d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_READY};
        else        fsm_q <= fsm_d;
    end

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter  int SETS = 64,
    parameter  int WAYS = 4,
    localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_rd,
    input  logic            req_wr,
    input  logic            hit,
    input  logic            line_dirty,
    input  logic            pipe_stall,
    input  logic            flush_cmd,
    input  logic            inval_cmd,
    input  logic            bus_ack,
    output logic            stall,
    output logic            array_en,
    output logic            bus_rd_req,
    output logic            bus_wr_req,
    output logic            clr_dirty,
    output logic            clr_valid,
    output logic            flush_done,
    output logic [SETW-1:0] flush_set,
    output logic [WAYW-1:0] flush_way
);

    wbc_ctl_t ctl;
    logic     walk_last;

    wbc_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .hit        (hit),
        .line_dirty (line_dirty),
        .pipe_stall (pipe_stall),
        .flush_cmd  (flush_cmd),
        .inval_cmd  (inval_cmd),
        .bus_ack    (bus_ack),
        .walk_last  (walk_last),
        .ctl        (ctl)
    );

    wbc_flush_walk #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) i_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl.walk_clear),
        .adv     (ctl.walk_adv),
        .set_idx (flush_set),
        .way_idx (flush_way),
        .last    (walk_last)
    );

    assign stall      = ctl.stall;
    assign array_en   = ctl.array_en;
    assign bus_rd_req = ctl.bus_rd;
    assign bus_wr_req = ctl.bus_wr;
    assign clr_dirty  = ctl.clr_dirty;
    assign clr_valid  = ctl.clr_valid;
    assign flush_done = ctl.flush_done;

endmodule

// File: rtl/wbc_ctrl_chk.sv
module wbc_ctrl_chk #(
    parameter int SETW = 6,
    parameter int WAYW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_rd,
    input logic            req_wr,
    input logic            hit,
    input logic            pipe_stall,
    input logic            flush_cmd,
    input logic            inval_cmd,
    input logic            stall,
    input logic            array_en,
    input logic            bus_rd_req,
    input logic            bus_wr_req,
    input logic            clr_dirty,
    input logic            clr_valid,
    input logic            flush_done,
    input logic [SETW-1:0] flush_set,
    input logic [WAYW-1:0] flush_way
);

    assert_inval_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (array_en && !stall));

    assert_aen_low_stalled_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !array_en |-> (hit && pipe_stall && (req_rd || req_wr) && !stall && !inval_cmd && !flush_cmd));

    assert_wr_holds_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_req |-> stall);

    assert_rd_holds_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_req |-> stall);

    assert_clr_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dirty |=> (bus_wr_req && $stable(flush_set) && $stable(flush_way)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    assert_done_wrapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (stall && flush_set == '0 && flush_way == '0));

    assert_bus_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_req && bus_wr_req));

endmodule

bind wbc_ctrl wbc_ctrl_chk #(
    .SETW (SETW),
    .WAYW (WAYW)
) i_wbc_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_rd     (req_rd),
    .req_wr     (req_wr),
    .hit        (hit),
    .pipe_stall (pipe_stall),
    .flush_cmd  (flush_cmd),
    .inval_cmd  (inval_cmd),
    .stall      (stall),
    .array_en   (array_en),
    .bus_rd_req (bus_rd_req),
    .bus_wr_req (bus_wr_req),
    .clr_dirty  (clr_dirty),
    .clr_valid  (clr_valid),
    .flush_done (flush_done),
    .flush_set  (flush_set),
    .flush_way  (flush_way)
);

// File: tb/test_wbc_ctrl.sv
module test_wbc_ctrl;

    localparam int PERIOD = 10;
    localparam int SETS   = 4;
    localparam int WAYS   = 2;
    localparam int LINES  = SETS * WAYS;
    localparam int SW     = 2;
    localparam int WW     = 1;
    localparam int OBSW   = 7 + SW + WW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rd = 0, req_wr = 0, hit = 0, pipe_stall = 0;
    logic flush_cmd = 0, inval_cmd = 0, bus_ack = 0;
    logic line_dirty;
    logic stall, array_en, bus_rd_req, bus_wr_req, clr_dirty, clr_valid, flush_done;
    logic [SW-1:0] flush_set;
    logic [WW-1:0] flush_way;

    logic [LINES-1:0] dmask = '0;
    logic             in_flush = 1'b0;
    logic             miss_dirty = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    // behavioural dirty-bit store
    assign line_dirty = in_flush ? dmask[int'(flush_set) * WAYS + int'(flush_way)] : miss_dirty;

    always @(posedge clk)
        if (clr_dirty) dmask[int'(flush_set) * WAYS + int'(flush_way)] <= 1'b0;

    wbc_ctrl #(.SETS(SETS), .WAYS(WAYS)) i_wbc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .hit(hit),
        .line_dirty(line_dirty), .pipe_stall(pipe_stall), .flush_cmd(flush_cmd),
        .inval_cmd(inval_cmd), .bus_ack(bus_ack), .stall(stall), .array_en(array_en),
        .bus_rd_req(bus_rd_req), .bus_wr_req(bus_wr_req), .clr_dirty(clr_dirty),
        .clr_valid(clr_valid), .flush_done(flush_done), .flush_set(flush_set),
        .flush_way(flush_way)
    );

    function automatic logic [OBSW-1:0] mk(logic st, logic ae, logic rd, logic wr,
                                           logic cd, logic cv, logic dn, int idx);
        logic [SW-1:0] s = SW'(idx / WAYS);
        logic [WW-1:0] w = WW'(idx % WAYS);
        return {st, ae, rd, wr, cd, cv, dn, s, w};
    endfunction

    function automatic logic [OBSW-1:0] obs();
        return {stall, array_en, bus_rd_req, bus_wr_req, clr_dirty, clr_valid,
                flush_done, flush_set, flush_way};
    endfunction

    task automatic check(string tag, logic [OBSW-1:0] exp);
        logic [OBSW-1:0] act = obs();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (stall,aen,rd,wr,cdirty,cvalid,done,set,way)",
                     tag, act, exp);
        end
    endtask

    // drive at falling edge, sample one time unit later
    task automatic step(logic rd, logic wr, logic h, logic ps, logic fl, logic inv, logic ack);
        @(negedge clk);
        req_rd = rd; req_wr = wr; hit = h; pipe_stall = ps;
        flush_cmd = fl; inval_cmd = inv; bus_ack = ack;
        #1;
    endtask

    task automatic run_miss(logic wr, logic d, logic ps, int lat);
        in_flush = 1'b0; miss_dirty = d;
        step(!wr, wr, 0, 0, 0, 0, 0);
        check("R3 miss accept", mk(1, 1, 0, 0, 0, 0, 0, 0));
        if (d) begin
            for (int k = 0; k < lat; k++) begin
                step(!wr, wr, 0, 0, 0, 0, 0);
                check("R3 victim write wait", mk(1, 1, 0, 1, 0, 0, 0, 0));
            end
            step(!wr, wr, 0, 0, 0, 0, 1);
            check("R3 victim write ack", mk(1, 1, 0, 1, 0, 0, 0, 0));
        end
        for (int k = 0; k < lat; k++) begin
            step(!wr, wr, 0, 0, 0, 0, 0);
            check("R4 fetch wait", mk(1, 1, 1, 0, 0, 0, 0, 0));
        end
        step(!wr, wr, 0, ps, 0, 0, 1);
        check("R4 fetch ack", mk(1, 1, 1, 0, 0, 0, 0, 0));
        if (ps) begin
            for (int k = 0; k < 2; k++) begin
                step(!wr, wr, 0, 1, 0, 0, 0);
                check("R5 hold stalled", mk(0, 1, 0, 0, 0, 0, 0, 0));
            end
            step(!wr, wr, 0, 0, 0, 0, 0);
            check("R5 hold release", mk(0, 1, 0, 0, 0, 0, 0, 0));
        end
        // back in ready: a stalled hit must drop the enable
        step(!wr, wr, 1, 1, 0, 0, 0);
        check("R5 ready after refill", mk(0, 0, 0, 0, 0, 0, 0, 0));
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic run_flush(logic [LINES-1:0] mask, int lat);
        dmask = mask; in_flush = 1'b1;
        step(0, 0, 0, 0, 1, 0, 0);
        check("R6 flush accept", mk(1, 1, 0, 0, 0, 0, 0, 0));
        for (int idx = 0; idx < LINES; idx++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            check(mask[idx] ? "R8 dirty line check" : "R7 clean line skip",
                  mk(1, 1, 0, 0, mask[idx], 0, 0, idx));
            if (mask[idx]) begin
                for (int k = 0; k < lat; k++) begin
                    step(0, 0, 0, 0, 0, 0, 0);
                    check("R8 line write wait", mk(1, 1, 0, 1, 0, 0, 0, idx));
                end
                step(0, 0, 0, 0, 0, 0, 1);
                check("R8 line write ack", mk(1, 1, 0, 1, 0, 0, 0, idx));
            end
        end
        step(0, 0, 0, 0, 0, 0, 0);
        check("R9 flush done", mk(1, 1, 0, 0, 0, 0, 1, 0));
        step(0, 0, 0, 0, 0, 0, 0);
        check("R9 ready after flush", mk(0, 1, 0, 0, 0, 0, 0, 0));
        checks++;
        if (dmask !== '0) begin
            errors++;
            $display("FAIL R8 dirty store: actual=%b expected=%b", dmask, {LINES{1'b0}});
        end
        in_flush = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset state", mk(0, 1, 0, 0, 0, 0, 0, 0));

        // ready-state sweep: {inv, fl, rd, wr, hit, ps}, reset between combos
        for (int c = 0; c < 64; c++) begin
            logic inv = c[5], fl = c[4], rd = c[3], wr = c[2], h = c[1], ps = c[0];
            logic [OBSW-1:0] exp;
            if (inv)                    exp = mk(0, 1, 0, 0, 0, 1, 0, 0);
            else if (fl)                exp = mk(1, 1, 0, 0, 0, 0, 0, 0);
            else if ((rd | wr) && !h)   exp = mk(1, 1, 0, 0, 0, 0, 0, 0);
            else if ((rd | wr) && ps)   exp = mk(0, 0, 0, 0, 0, 0, 0, 0);
            else                        exp = mk(0, 1, 0, 0, 0, 0, 0, 0);
            step(rd, wr, h, ps, fl, inv, 0);
            check(inv ? "R1 invalidate priority" : "R2 ready outputs", exp);
            #1 rst_n = 1'b0;
            @(negedge clk);
            req_rd = 0; req_wr = 0; hit = 0; pipe_stall = 0;
            flush_cmd = 0; inval_cmd = 0; bus_ack = 0;
            rst_n = 1'b1;
        end

        for (int m = 0; m < 16; m++)
            run_miss(m[3], m[2], m[1], m[0] ? 2 : 0);

        for (int m = 0; m < (1 << LINES); m++)
            run_flush(LINES'(m), 1);
        run_flush('1, 0);
        run_flush('1, 3);
        run_flush(8'hA5, 0);
        run_flush(8'h5A, 3);

        // a miss straight after a flush still works
        run_miss(1'b1, 1'b1, 1'b0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule